// File: doc/BRIEF.md
# Next-PC and Link Unit

This block holds the program counter and works out the address of the following instruction. It takes a small instruction-class code, a signed PC-relative offset and one register operand. From these it returns the next PC and a flag that shows a transfer of control. For the two linking classes it also returns a register-file write of the return address. Fetch, decode and the register file sit outside the block. Decode supplies the class, the offset field and the value of the tested or target register.

All relative targets are measured from the address of the following instruction (PC+4). Direct jumps carry a 26-bit byte offset. Conditional branches carry a 16-bit byte offset. Both are sign-extended, and the target arithmetic wraps modulo 2^32. A conditional branch tests one register against zero. The combinational outputs describe the instruction presented now. The PC register takes the computed address on a clock edge where the advance enable is high.

Top module: `npc_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, the PC reads 0.
- R2: Class code 0 (sequential), and the unused code 7, give next PC = PC+4 with the taken flag low.
- R3: Class codes 1 (jump) and 2 (jump and link) give next PC = PC+4 + sign-extended offset[25:0], wrapping modulo 2^32, with taken high.
- R4: Class codes 5 and 6 (branches) use only offset[15:0], sign-extended and added to PC+4. Offset bits 25:16 have no effect on the result.
- R5: Code 5 is taken when the operand is zero and code 6 is taken when it is nonzero. A branch that is not taken gives PC+4 with taken low.
- R6: Class codes 3 (jump register) and 4 (jump and link register) give next PC = operand, with taken high.
- R7: With advance high, codes 2 and 4 raise the link write enable. The link address is then 31 and the link data is PC+4. Every other code keeps the link write enable low.
- R8: On a clock edge with advance high, the PC loads the computed next PC. With advance low, the PC holds and the link write enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv | input | 1 | Advance enable: commit the next PC and allow the link write |
| kind | input | 3 | Instruction class code |
| offset | input | 26 | Signed byte offset; branches use bits 15:0 |
| opnd | input | 32 | Register operand (tested value or jump target) |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address of the following instruction |
| taken | output | 1 | Control transfer for the current instruction |
| link_we | output | 1 | Return-address write enable |
| link_addr | output | 5 | Destination register of the link write |
| link_data | output | 32 | Return address written on link |

## Verification
The properties assume that kind, offset and opnd are stable in the cycle they are sampled. They also assume that adv alone decides whether the PC moves, so any class code, including the unused one, is legal input. The bench drives every input on the falling edge and samples a few nanoseconds later, so each input is settled well before the rising edge that commits it. The counted loop derives the branch operand from the bench's own model of the loop registers. Directed steps exercise the offset extremes and PC wrap-around.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN       = 32;
  localparam int JOFF_W     = 26;
  localparam int BOFF_W     = 16;
  localparam int RADDR_W    = 5;
  localparam int KIND_W     = 3;

  typedef enum logic [KIND_W-1:0] {
    K_SEQ  = 3'd0,
    K_JMP  = 3'd1,
    K_JAL  = 3'd2,
    K_JR   = 3'd3,
    K_JALR = 3'd4,
    K_BEQZ = 3'd5,
    K_BNEZ = 3'd6,
    K_RSVD = 3'd7
  } kind_e;
endpackage

// File: rtl/npc_targets.sv
module npc_targets #(
  parameter int XLEN       = 32,
  parameter int JOFF_W     = 26,
  parameter int BOFF_W     = 16,
  parameter int INSN_BYTES = 4
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [JOFF_W-1:0] offset,
  output logic [XLEN-1:0]   seq_pc,
  output logic [XLEN-1:0]   jmp_tgt,
  output logic [XLEN-1:0]   br_tgt
);
  localparam int JEXT = XLEN - JOFF_W;
  localparam int BEXT = XLEN - BOFF_W;

  logic [XLEN-1:0] jmp_sext;
  logic [XLEN-1:0] br_sext;

  // Widen both offsets to the full address width, carrying the sign bit.
  generate
    if (JEXT > 0) begin : g_jext
      assign jmp_sext = {{JEXT{offset[JOFF_W-1]}}, offset};
    end else begin : g_jfull
      assign jmp_sext = offset[XLEN-1:0];
    end
    if (BEXT > 0) begin : g_bext
      assign br_sext = {{BEXT{offset[BOFF_W-1]}}, offset[BOFF_W-1:0]};
    end else begin : g_bfull
      assign br_sext = offset[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    seq_pc  = pc + XLEN'(INSN_BYTES);
    jmp_tgt = seq_pc + jmp_sext;
    br_tgt  = seq_pc + br_sext;
  end
endmodule

// File: rtl/npc_resolve.sv
module npc_resolve
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [KIND_W-1:0] kind,
  input  logic [XLEN-1:0]   opnd,
  input  logic [XLEN-1:0]   seq_pc,
  input  logic [XLEN-1:0]   jmp_tgt,
  input  logic [XLEN-1:0]   br_tgt,
  output logic [XLEN-1:0]   next_pc,
  output logic              taken,
  output logic              is_link
);
  logic opnd_zero;

  always_comb begin
    opnd_zero = (opnd == '0);
    next_pc   = seq_pc;
    taken     = 1'b0;
    is_link   = 1'b0;
    unique case (kind_e'(kind))
      K_JMP: begin
        next_pc = jmp_tgt;
        taken   = 1'b1;
      end
      K_JAL: begin
        next_pc = jmp_tgt;
        taken   = 1'b1;
        is_link = 1'b1;
      end
      K_JR: begin
        next_pc = opnd;
        taken   = 1'b1;
      end
      K_JALR: begin
        next_pc = opnd;
        taken   = 1'b1;
        is_link = 1'b1;
      end
      K_BEQZ: begin
        taken   = opnd_zero;
        next_pc = opnd_zero ? br_tgt : seq_pc;
      end
      K_BNEZ: begin
        taken   = !opnd_zero;
        next_pc = opnd_zero ? seq_pc : br_tgt;
      end
      default: begin
        next_pc = seq_pc;
        taken   = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/npc_link.sv
module npc_link #(
  parameter int XLEN     = 32,
  parameter int RADDR_W  = 5,
  parameter int LINK_REG = 31
) (
  input  logic               adv,
  input  logic               is_link,
  input  logic [XLEN-1:0]    seq_pc,
  output logic               link_we,
  output logic [RADDR_W-1:0] link_addr,
  output logic [XLEN-1:0]    link_data
);
  always_comb begin
    link_we   = adv & is_link;
    link_addr = RADDR_W'(LINK_REG);
    link_data = seq_pc;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int          INSN_BYTES = 4,
  parameter int          LINK_REG   = 31,
  parameter logic [31:0] RESET_PC   = 32'h0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic [KIND_W-1:0]  kind,
  input  logic [JOFF_W-1:0]  offset,
  input  logic [XLEN-1:0]    opnd,
  output logic [XLEN-1:0]    pc,
  output logic [XLEN-1:0]    next_pc,
  output logic               taken,
  output logic               link_we,
  output logic [RADDR_W-1:0] link_addr,
  output logic [XLEN-1:0]    link_data
);
  logic [XLEN-1:0] pc_q, pc_d;
  logic [XLEN-1:0] seq_pc, jmp_tgt, br_tgt;
  logic            is_link;

  npc_targets #(
    .XLEN(XLEN), .JOFF_W(JOFF_W), .BOFF_W(BOFF_W), .INSN_BYTES(INSN_BYTES)
  ) u_targets (
    .pc(pc_q), .offset(offset),
    .seq_pc(seq_pc), .jmp_tgt(jmp_tgt), .br_tgt(br_tgt)
  );

  npc_resolve #(.XLEN(XLEN)) u_resolve (
    .kind(kind), .opnd(opnd), .seq_pc(seq_pc), .jmp_tgt(jmp_tgt),
    .br_tgt(br_tgt), .next_pc(next_pc), .taken(taken), .is_link(is_link)
  );

  npc_link #(.XLEN(XLEN), .RADDR_W(RADDR_W), .LINK_REG(LINK_REG)) u_link (
    .adv(adv), .is_link(is_link), .seq_pc(seq_pc),
    .link_we(link_we), .link_addr(link_addr), .link_data(link_data)
  );

  // Next-state: the clock enable is written out as a hold path.
  always_comb begin
    pc_d = pc_q;
    if (adv) pc_d = next_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_d;
  end

  assign pc = pc_q;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk
  import npc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               adv,
  input logic [KIND_W-1:0]  kind,
  input logic [JOFF_W-1:0]  offset,
  input logic [XLEN-1:0]    opnd,
  input logic [XLEN-1:0]    pc,
  input logic [XLEN-1:0]    next_pc,
  input logic               taken,
  input logic               link_we
);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pc));

  a_r8_commit: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> pc == $past(next_pc));

  a_r5_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    !taken |-> next_pc == pc + 32'd4);

  a_r6_reg_target: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_JR || kind == K_JALR) |-> (taken && next_pc == opnd));

  a_r5_zero_test: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_BEQZ) |-> (taken == (opnd == '0)));

  a_r7_link_only: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (adv && (kind == K_JAL || kind == K_JALR)));

  a_r2_seq_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_SEQ || kind == K_RSVD) |-> !taken);
endmodule

bind npc_unit npc_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .adv(adv), .kind(kind), .offset(offset),
  .opnd(opnd), .pc(pc), .next_pc(next_pc), .taken(taken), .link_we(link_we)
);

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
  import npc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        adv;
  logic [2:0]  kind;
  logic [25:0] offset;
  logic [31:0] opnd;
  logic [31:0] pc, next_pc, link_data;
  logic        taken, link_we;
  logic [4:0]  link_addr;

  typedef struct {
    logic [31:0] pc;
    logic [31:0] npc;
    logic        tk;
    logic        lwe;
    logic [31:0] ldata;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  logic [31:0] m_pc;
  bit finished = 0;

  always #5 clk = ~clk;

  npc_unit u_npc_unit (
    .clk(clk), .rst_n(rst_n), .adv(adv), .kind(kind), .offset(offset),
    .opnd(opnd), .pc(pc), .next_pc(next_pc), .taken(taken),
    .link_we(link_we), .link_addr(link_addr), .link_data(link_data)
  );

  task automatic chk32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one instruction and queues the expected result.
  task automatic step(logic a, logic [2:0] k, logic [25:0] off, logic [31:0] op, string tag);
    item_t it;
    logic [31:0] seq;
    @(negedge clk);
    adv = a; kind = k; offset = off; opnd = op;
    seq = m_pc + 32'd4;
    it.pc = m_pc; it.tk = 1'b0; it.npc = seq; it.tag = tag;
    case (k)
      3'd1, 3'd2: begin it.tk = 1'b1; it.npc = seq + 32'($signed(off)); end
      3'd3, 3'd4: begin it.tk = 1'b1; it.npc = op; end
      3'd5: if (op == 0) begin it.tk = 1'b1; it.npc = seq + 32'($signed(off[15:0])); end
      3'd6: if (op != 0) begin it.tk = 1'b1; it.npc = seq + 32'($signed(off[15:0])); end
      default: ;
    endcase
    it.lwe   = a && (k == 3'd2 || k == 3'd4);
    it.ldata = seq;
    q.push_back(it);
    if (a) m_pc = it.npc;
  endtask

  // Monitor: samples 3 ns after the falling edge and compares.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk32(it.tag, "pc", pc, it.pc);
        chk32(it.tag, "next_pc", next_pc, it.npc);
        chk32(it.tag, "taken", {31'd0, taken}, {31'd0, it.tk});
        chk32(it.tag, "link_we", {31'd0, link_we}, {31'd0, it.lwe});
        if (it.lwe) begin
          chk32(it.tag, "link_data", link_data, it.ldata);
          chk32(it.tag, "link_addr", {27'd0, link_addr}, 32'd31);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] r4, r5, r12;
    int guard;
    rst_n = 1'b0; adv = 1'b0; kind = '0; offset = '0; opnd = '0; m_pc = 32'h0;
    repeat (2) @(negedge clk);
    #3 chk32("R1", "pc in reset", pc, 32'h0);
    rst_n = 1'b1;
    // R1: first cycle after release; R8: advance low holds.
    step(1'b0, 3'd0, 26'h0, 32'h0, "R1");
    step(1'b0, 3'd2, 26'h10, 32'h0, "R8");
    // Counted loop (n = 3): exits through a zero branch to address 40.
    r4 = 0; r5 = 0; r12 = 0; guard = 0;
    while (m_pc != 32'd40 && guard < 100) begin
      guard++;
      case (m_pc)
        32'd0:  begin step(1'b1, 3'd0, 26'h0, 32'h0, "R2"); r5 = 32'd12; end
        32'd4:  begin step(1'b1, 3'd0, 26'h0, 32'h0, "R2"); r4 = 0; end
        32'd8:  begin r12 = (r4 < r5) ? 1 : 0; step(1'b1, 3'd0, 26'h0, 32'h0, "R2"); end
        32'd12: step(1'b1, 3'd5, 26'd24, r12, "R5");
        32'd32: begin step(1'b1, 3'd0, 26'h0, 32'h0, "R2"); r4 = r4 + 4; end
        32'd36: step(1'b1, 3'd1, 26'h3FFFFE0, 32'h0, "R3");
        default: step(1'b1, 3'd0, 26'h0, 32'h0, "R2");
      endcase
    end
    chk32("R5", "loop exit pc", m_pc, 32'd40);
    chk32("R5", "loop count", r4, 32'd12);
    // Offset extremes and wrap-around.
    step(1'b1, 3'd1, 26'h1FFFFFC, 32'h0, "R3");
    step(1'b1, 3'd2, 26'h2000000, 32'h0, "R7");
    step(1'b1, 3'd4, 26'h0, 32'hFFFF_FFF8, "R7");
    step(1'b1, 3'd1, 26'h8, 32'h0, "R3");
    // Branch: upper offset bits ignored, negative offset, not-taken paths.
    step(1'b1, 3'd5, 26'h3FF0010, 32'h0, "R4");
    step(1'b1, 3'd6, 26'h000FFF0, 32'h5, "R4");
    step(1'b1, 3'd5, 26'h0000100, 32'h1, "R5");
    step(1'b1, 3'd6, 26'h0000100, 32'h0, "R5");
    step(1'b1, 3'd3, 26'h1234, 32'h0000_4000, "R6");
    step(1'b1, 3'd7, 26'h3FFFFFF, 32'h0, "R2");
    step(1'b0, 3'd4, 26'h0, 32'h0000_8000, "R8");
    step(1'b1, 3'd0, 26'h0, 32'h0, "R8");
    repeat (3) @(negedge clk);
    #4;
    chk32("R8", "queue drained", q.size(), 32'd0);
    finish_run();
  end
endmodule